// File: doc/BRIEF.md
# NAND Cache-Program Status Tracker

This block holds the state behind the status byte of a NAND flash device that can pipeline page programs through a cache register. It watches events from the array controller and the cache register. Those events are: an operation starts, the final array operation completes, the cache register is loaded, and cache data moves to the page buffer. It also receives the pass/fail result of each page program or erase. From these it keeps two busy flags and a two-entry record of page outcomes.

The record works in cache mode. When a new cache page is accepted, the current page's outcome moves into the previous-page slot, and the current slot stays clear until that page's result arrives. A host read-status strobe captures the live byte into an output register, and that register does not change until the next strobe.

Top module: `nand_cache_status`

## Requirements
- R1: After reset, `status_q` is 0x00. The controller and the cache register are idle, both error flags are clear, and cache mode is off.
- R2: Bit 7 of a captured byte equals `wp_n`: 1 means not protected, 0 means protected.
- R3: Bit 5 is 0 from the edge that samples `op_start` until the edge that samples `op_done`. If both are sampled at the same edge, `op_start` wins.
- R4: In cache mode, bit 6 is 0 from the edge that samples `cache_load` until the edge that samples `cache_release`, and `cache_load` wins if both arrive together. Outside cache mode, bit 6 equals bit 5.
- R5: Bits 4, 3 and 2 are always 0.
- R6: A sampled `res_valid` writes `res_fail` into bit 0, the current-page error.
- R7: In cache mode, a sampled `cache_load` moves bit 0 into bit 1 and clears bit 0. If `res_valid` arrives on the same edge, `res_fail` goes to bit 1 and bit 0 is cleared.
- R8: Bit 1 reads 0 whenever cache mode is off.
- R9: Any sampled `op_start` clears both error flags, and this takes priority over results and loads.
- R10: `status_q` takes the live byte at an edge where `rd_stb` is 1 and holds its value at every other edge.
- R11: Cache mode begins when `op_start` is sampled with `op_cache` = 1. It ends on `op_done`, or on `op_start` with `op_cache` = 0.
- R12: Outside cache mode, a `cache_load` leaves both error bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin level, 0 = protected |
| op_start | input | 1 | Controller operation begins (one cycle) |
| op_cache | input | 1 | Qualifies `op_start`: the operation is a cache program |
| op_done | input | 1 | Final array operation completed (one cycle) |
| cache_load | input | 1 | New page accepted into the cache register |
| cache_release | input | 1 | Cache data moved to the page buffer |
| res_valid | input | 1 | A page program or erase result is available |
| res_fail | input | 1 | Result value, 1 = failed |
| rd_stb | input | 1 | Read-status strobe |
| status_q | output | 8 | Captured status byte |

## Verification
The hardest case to reach is a result that arrives on the same edge as the next cache load, in the middle of a long cache sequence. Here the result has to land in the previous-page bit and not in the current-page bit. The bench runs cache programs of three pages with every pass/fail pattern. It merges each page's result with the following load on one edge, and it also issues them on separate edges. After each step it reads the status back and compares it with a model computed from the requirements. This covers every combination of the two error bits at every position in the pipeline.

// File: rtl/ncs_pkg.sv
package ncs_pkg;
  localparam int STAT_W  = 8;
  localparam int B_WP    = 7;
  localparam int B_CRDY  = 6;
  localparam int B_ARDY  = 5;
  localparam int B_PERR  = 1;
  localparam int B_CERR  = 0;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic wp_n, input logic cmode, input logic cbusy,
    input logic abusy, input logic eprev, input logic ecur);
    logic [STAT_W-1:0] s;
    s = '0;
    s[B_WP]   = wp_n;
    s[B_ARDY] = ~abusy;
    s[B_CRDY] = cmode ? ~cbusy : ~abusy;
    s[B_PERR] = cmode & eprev;
    s[B_CERR] = ecur;
    return s;
  endfunction
endpackage

// File: rtl/ncs_busy_track.sv
module ncs_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic op_cache,
  input  logic op_done,
  input  logic cache_load,
  input  logic cache_release,
  output logic array_busy,
  output logic cache_busy,
  output logic cache_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      array_busy <= 1'b0;
      cache_mode <= 1'b0;
    end else if (op_start) begin
      array_busy <= 1'b1;
      cache_mode <= op_cache;
    end else if (op_done) begin
      array_busy <= 1'b0;
      cache_mode <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cache_busy <= 1'b0;
    else if (cache_load)    cache_busy <= 1'b1;
    else if (cache_release) cache_busy <= 1'b0;
  end
endmodule

// File: rtl/ncs_err_pipe.sv
module ncs_err_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic cache_mode,
  input  logic cache_load,
  input  logic res_valid,
  input  logic res_fail,
  output logic err_cur,
  output logic err_prev,
  output logic page_shift
);
  assign page_shift = cache_load & cache_mode & ~op_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cur  <= 1'b0;
      err_prev <= 1'b0;
    end else if (op_start) begin
      err_cur  <= 1'b0;
      err_prev <= 1'b0;
    end else if (page_shift) begin
      err_prev <= res_valid ? res_fail : err_cur;
      err_cur  <= 1'b0;
    end else if (res_valid) begin
      err_cur  <= res_fail;
    end
  end
endmodule

// File: rtl/ncs_snap.sv
module ncs_snap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_stb,
  input  logic [W-1:0] live,
  output logic [W-1:0] snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap <= '0;
    else if (rd_stb) snap <= live;
  end
endmodule

// File: rtl/nand_cache_status.sv
module nand_cache_status
  import ncs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              op_start,
  input  logic              op_cache,
  input  logic              op_done,
  input  logic              cache_load,
  input  logic              cache_release,
  input  logic              res_valid,
  input  logic              res_fail,
  input  logic              rd_stb,
  output logic [STAT_W-1:0] status_q
);
  logic array_busy, cache_busy, cache_mode;
  logic err_cur, err_prev, page_shift;
  logic [STAT_W-1:0] live_status;

  ncs_busy_track u_busy (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_cache(op_cache),
    .op_done(op_done), .cache_load(cache_load), .cache_release(cache_release),
    .array_busy(array_busy), .cache_busy(cache_busy), .cache_mode(cache_mode)
  );

  ncs_err_pipe u_err (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .cache_mode(cache_mode),
    .cache_load(cache_load), .res_valid(res_valid), .res_fail(res_fail),
    .err_cur(err_cur), .err_prev(err_prev), .page_shift(page_shift)
  );

  assign live_status = pack_status(wp_n, cache_mode, cache_busy,
                                   array_busy, err_prev, err_cur);

  ncs_snap #(.W(STAT_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .live(live_status), .snap(status_q)
  );
endmodule

// File: rtl/nand_cache_status_chk.sv
module nand_cache_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       op_start,
  input logic       op_done,
  input logic       cache_load,
  input logic       res_valid,
  input logic       rd_stb,
  input logic       array_busy,
  input logic       cache_mode,
  input logic       err_cur,
  input logic       err_prev,
  input logic [7:0] status_q
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[4:2] == 3'b000); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(status_q)); // R10
  AST_WP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> status_q[7] == $past(wp_n)); // R2
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> array_busy); // R3
  AST_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && !op_start |=> !array_busy); // R3
  AST_PREV_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !cache_mode |=> !status_q[1]); // R8
  AST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cache_load && cache_mode && !op_start && !res_valid
      |=> err_prev == $past(err_cur) && !err_cur); // R7
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !err_cur && !err_prev); // R9
endmodule

bind nand_cache_status nand_cache_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op_start(op_start), .op_done(op_done),
  .cache_load(cache_load), .res_valid(res_valid), .rd_stb(rd_stb),
  .array_busy(array_busy), .cache_mode(cache_mode), .err_cur(err_cur),
  .err_prev(err_prev), .status_q(status_q)
);

// File: tb/nand_cache_status_tb.sv
module nand_cache_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1, op_start = 1'b0, op_cache = 1'b0, op_done = 1'b0;
  logic cache_load = 1'b0, cache_release = 1'b0, res_valid = 1'b0, res_fail = 1'b0;
  logic rd_stb = 1'b0;
  logic [7:0] status_q;

  int n_chk = 0, n_bad = 0;
  bit m_busy = 0, m_cbusy = 0, m_cmode = 0, m_ecur = 0, m_eprev = 0;

  always #5 clk = ~clk;

  nand_cache_status u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op_start(op_start), .op_cache(op_cache),
    .op_done(op_done), .cache_load(cache_load), .cache_release(cache_release),
    .res_valid(res_valid), .res_fail(res_fail), .rd_stb(rd_stb), .status_q(status_q)
  );

  function automatic logic [7:0] expect_byte();
    int v;
    v = 0;
    if (wp_n) v += 128;
    if (m_cmode ? !m_cbusy : !m_busy) v += 64;
    if (!m_busy) v += 32;
    if (m_cmode && m_eprev) v += 2;
    if (m_ecur) v += 1;
    return v[7:0];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req);
    logic [7:0] e;
    e = expect_byte();
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    check(req, status_q, e);
  endtask

  task automatic do_start(input bit cache);
    @(negedge clk) begin op_start = 1'b1; op_cache = cache; end
    @(negedge clk) begin op_start = 1'b0; op_cache = 1'b0; end
    m_busy = 1; m_cmode = cache; m_ecur = 0; m_eprev = 0;
  endtask

  task automatic do_done();
    @(negedge clk) op_done = 1'b1;
    @(negedge clk) op_done = 1'b0;
    m_busy = 0; m_cmode = 0;
  endtask

  task automatic do_load(input bit with_res, input bit f);
    @(negedge clk) begin cache_load = 1'b1; res_valid = with_res; res_fail = f; end
    @(negedge clk) begin cache_load = 1'b0; res_valid = 1'b0; res_fail = 1'b0; end
    m_cbusy = 1;
    if (m_cmode) begin
      m_eprev = with_res ? f : m_ecur;
      m_ecur = 0;
    end else if (with_res) m_ecur = f;
  endtask

  task automatic do_release();
    @(negedge clk) cache_release = 1'b1;
    @(negedge clk) cache_release = 1'b0;
    m_cbusy = 0;
  endtask

  task automatic do_result(input bit f);
    @(negedge clk) begin res_valid = 1'b1; res_fail = f; end
    @(negedge clk) begin res_valid = 1'b0; res_fail = 1'b0; end
    m_ecur = f;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset byte", status_q, 8'h00);
    rst_n = 1'b1;
    rd_check("R1 idle after reset");
    wp_n = 1'b0;
    rd_check("R2 protected");
    wp_n = 1'b1;
    rd_check("R2 unprotected");

    // non-cache program that fails
    do_start(0);
    rd_check("R3 busy after start");
    rd_check("R4 bit6 mirrors bit5 outside cache");
    do_result(1);
    do_done();
    rd_check("R6 fail reported");
    do_load(0, 0);
    rd_check("R12 load outside cache mode");
    do_release();
    do_start(0);
    rd_check("R9 start clears errors");
    do_result(0);
    do_done();
    rd_check("R6 pass reported");

    // R10 hold: change state without strobe
    held = status_q;
    do_start(0);
    do_result(1);
    check("R10 hold without strobe", status_q, held);
    do_done();
    rd_check("R10 capture on strobe");

    // simultaneous start and done: start wins
    @(negedge clk) begin op_start = 1'b1; op_done = 1'b1; end
    @(negedge clk) begin op_start = 1'b0; op_done = 1'b0; end
    m_busy = 1; m_cmode = 0; m_ecur = 0; m_eprev = 0;
    rd_check("R3 start wins over done");
    do_done();

    // sweep all result patterns over three cache pages, both timings
    for (int mode = 0; mode < 2; mode++) begin
      for (int pat = 0; pat < 8; pat++) begin
        bit pend;
        bit pf;
        pend = 0; pf = 0;
        wp_n = pat[0];
        do_start(1);
        rd_check("R11 cache mode entered");
        for (int pg = 0; pg < 3; pg++) begin
          bit f;
          f = pat[pg];
          do_load(pend, pf);
          pend = 0;
          rd_check("R7 page accepted, R4 cache busy");
          do_release();
          rd_check("R4 cache ready, R3 array busy");
          if (mode == 0) do_result(f);
          else begin pend = 1; pf = f; end
          rd_check("R6 current page result");
        end
        if (mode == 1) do_result(pf);
        do_load(0, 0);
        rd_check("R7 last shift");
        do_release();
        do_done();
        rd_check("R8 prev bit masked, R11 cache mode left");
      end
    end

    // simultaneous load and release: load wins
    do_start(1);
    @(negedge clk) begin cache_load = 1'b1; cache_release = 1'b1; end
    @(negedge clk) begin cache_load = 1'b0; cache_release = 1'b0; end
    m_cbusy = 1; m_eprev = m_ecur; m_ecur = 0;
    rd_check("R4 load wins over release");
    do_release();
    do_start(0);
    rd_check("R11 non-cache start leaves cache mode");
    do_done();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule